// File: doc/BRIEF.md
# Windowed Hotspot Detector and Path Throttler

This block watches the flit traffic of a group of network switches and turns it into a route-selection decision. Every switch reports one pulse for each flit it handles. The block counts these pulses over a fixed monitoring window. At the end of each window it compares each switch's count against a threshold, which is the density threshold multiplied by the window length. A switch that went over the threshold goes on the avoidance list. A per-switch run counter records how many windows in a row the switch has stayed on the list.

A route-selection client offers a ranked set of candidate paths. Each path is a bit mask of the switches it crosses, and candidate 0 is the preferred one. Each listed switch on a path passes traffic with probability 2^-run. A path's acceptance ratio is the product of these factors over its listed switches. A path that crosses no listed switch is always accepted. A free-running pseudo-random byte is compared against each ratio. The block chooses the best-ranked accepted candidate. When no candidate is accepted, it falls back to the preferred candidate. Congested switches are therefore made less attractive without ever being cut off completely.

Top module: `hotspot_throttle`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `avoid_list`, `hot_count` and `sel_vld` are all zero.
- R2: Windows are `WIN_CYCLES` clock cycles long. The first window starts at the first rising edge with reset high. A flit pulse in any cycle of a window counts toward that window, including the last cycle. If a switch's count is greater than `THRESH_FLITS`, its `avoid_list` bit is 1 from the cycle after the window's last cycle.
- R3: A switch whose count is less than or equal to `THRESH_FLITS` (equality included) leaves the list at the window boundary, and its run count returns to 0.
- R4: The run count of a switch is the 3-bit field `hot_count[3*s+2:3*s]`. It increases by one at each over-threshold boundary and stays at 7 once it reaches 7. A switch is listed exactly when its run count is non-zero.
- R5: `avoid_list` and `hot_count` change only in the cycle after a window's last cycle.
- R6: The random source is a 16-bit shift register. Its reset value is 0xACE1. On every clock with reset high it shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. The random byte used by a query is bits 15:8 of the register value in the query cycle.
- R7: A candidate's ratio is 256 shifted right by the sum of the run counts of the listed switches it crosses. The candidate is accepted when the random byte is less than that ratio. A candidate that crosses no listed switch has ratio 256 and is always accepted.
- R8: Candidate `c` occupies `qry_paths[NUM_SW*c +: NUM_SW]`. The lowest-numbered accepted candidate is chosen, and `sel_hit` is 1.
- R9: When no candidate is accepted, `sel_idx` is 0 and `sel_hit` is 0.
- R10: A query presented in cycle t is answered in cycle t+1. `sel_vld` is 1 in that cycle and 0 in every cycle that follows a cycle without a query. `sel_throttled` is 1 when the chosen candidate crosses a listed switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flit_evt | input | NUM_SW | One pulse per flit handled, one bit per switch |
| qry_vld | input | 1 | A ranked candidate set is offered this cycle |
| qry_paths | input | NCAND*NUM_SW | Switch masks of the candidates, candidate 0 first |
| avoid_list | output | NUM_SW | 1 for switches currently on the avoidance list |
| hot_count | output | 3*NUM_SW | Consecutive over-threshold windows, 3 bits per switch |
| sel_vld | output | 1 | Selection result is valid |
| sel_idx | output | IDX_W | Chosen candidate |
| sel_hit | output | 1 | 1 when the chosen candidate was accepted |
| sel_throttled | output | 1 | 1 when the chosen candidate crosses a listed switch |

## Verification
List and run-count updates fall due one cycle after the last cycle of a window, because the window comparison feeds a single register stage. Query results fall due one cycle after the query, from a single output register. The bench keeps a behavioural model that advances on the same rising edge as the design. It reads only the inputs the bench itself drove, and it compares every output at the following falling edge. The model decides acceptance with its own copy of the shift-register sequence and integer shifts. A directed stretch makes every candidate's ratio zero so that the fallback path is forced. Switch patterns are chosen to cross the threshold by exactly one flit, to sit exactly at the threshold, and to place the deciding flit in a window's last cycle.

// File: rtl/hs_pkg.sv
// Shared constants and helpers for the hotspot throttle.
// Assumes run counts of 3 bits and an 8-bit random fraction.
package hs_pkg;
    localparam int RUN_W   = 3;
    localparam int RUN_MAX = 7;
    localparam int FRAC_W  = 8;
    localparam int RATIO_W = FRAC_W + 1;

    typedef logic [RUN_W-1:0] run_t;

    // Acceptance ratio (out of 256) for a summed run count; zero once fully shifted out.
    function automatic logic [RATIO_W-1:0] ratio_of(input int unsigned shift);
        if (shift > FRAC_W) return '0;
        return RATIO_W'(256) >> shift;
    endfunction
endpackage

// File: rtl/hs_window_timer.sv
// Monitoring window timer: flags the last cycle of each WIN_CYCLES-long window.
// Assumes WIN_CYCLES >= 2; the first window starts at the first edge out of reset.
module hs_window_timer #(
    parameter int WIN_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int TW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

    logic [TW-1:0] pos_q;

    assign win_end = (pos_q == TW'(WIN_CYCLES - 1));

    // Position inside the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (win_end) pos_q <= '0;
        else              pos_q <= pos_q + TW'(1);
    end
endmodule

// File: rtl/hs_switch_mon.sv
// Per-switch monitor: counts flits over a window and keeps the list bit and run count.
// Assumes at most one flit pulse per cycle, so the count never exceeds WIN_CYCLES.
module hs_switch_mon
    import hs_pkg::*;
#(
    parameter int WIN_CYCLES   = 100,
    parameter int THRESH_FLITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flit_evt,
    input  logic win_end,
    output logic listed,
    output run_t run_cnt
);
    localparam int FW = $clog2(WIN_CYCLES + 1);

    logic [FW-1:0] flits_q;
    logic [FW-1:0] flits_now;
    logic          over;

    // Count including this cycle's pulse, so the last window cycle is included.
    assign flits_now = flits_q + FW'(flit_evt);
    assign over      = 32'(flits_now) > THRESH_FLITS;

    // Flit accumulation; restarts at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       flits_q <= '0;
        else if (win_end) flits_q <= '0;
        else              flits_q <= flits_now;
    end

    // List membership and consecutive run count, updated only at window boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            listed  <= 1'b0;
            run_cnt <= '0;
        end else if (win_end) begin
            listed  <= over;
            if (!over)                    run_cnt <= '0;
            else if (run_cnt != RUN_MAX)  run_cnt <= run_cnt + run_t'(1);
        end
    end
endmodule

// File: rtl/hs_lfsr.sv
// 16-bit Fibonacci shift register, taps 15/13/12/10, free running out of reset.
// Assumes a non-zero seed so the register never locks up.
module hs_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] rnd
);
    logic fb;

    assign fb = rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10];

    // Shift once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) rnd <= SEED;
        else        rnd <= {rnd[14:0], fb};
    end
endmodule

// File: rtl/hs_path_pick.sv
// Ranked path chooser: forms each candidate's ratio from the listed run counts,
// compares it with the random byte, and registers the best-ranked accepted one.
// Assumes candidate 0 is the preferred route and the fallback choice.
module hs_path_pick
    import hs_pkg::*;
#(
    parameter int NUM_SW = 8,
    parameter int NCAND  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    qry_vld,
    input  logic [NCAND*NUM_SW-1:0] qry_paths,
    input  logic [NUM_SW-1:0]       avoid_list,
    input  logic [RUN_W*NUM_SW-1:0] run_flat,
    input  logic [FRAC_W-1:0]       rnd_byte,
    output logic                    sel_vld,
    output logic [((NCAND > 1) ? $clog2(NCAND) : 1)-1:0] sel_idx,
    output logic                    sel_hit,
    output logic                    sel_throttled
);
    localparam int IDX_W   = (NCAND > 1) ? $clog2(NCAND) : 1;
    localparam int SUM_RAW = $clog2(NUM_SW * RUN_MAX + 1);
    localparam int SUM_W   = (SUM_RAW < 4) ? 4 : SUM_RAW;

    logic [NCAND-1:0] accept;
    logic [NCAND-1:0] crosses;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_hit;
    logic             pick_thr;

    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        logic [NUM_SW-1:0]  hot_on_path;
        logic [SUM_W-1:0]   shift_sum;
        logic [RATIO_W-1:0] ratio;

        assign hot_on_path = qry_paths[NUM_SW*c +: NUM_SW] & avoid_list;
        assign crosses[c]  = |hot_on_path;

        // Sum of run counts over the listed switches this candidate crosses.
        always_comb begin
            shift_sum = '0;
            for (int s = 0; s < NUM_SW; s++) begin
                if (hot_on_path[s]) shift_sum = shift_sum + SUM_W'(run_flat[RUN_W*s +: RUN_W]);
            end
        end

        assign ratio     = ratio_of(int'(shift_sum));
        assign accept[c] = {1'b0, rnd_byte} < ratio;
    end

    // Lowest-numbered accepted candidate wins; otherwise fall back to candidate 0.
    always_comb begin
        pick_idx = '0;
        pick_hit = 1'b0;
        for (int c = NCAND - 1; c >= 0; c--) begin
            if (accept[c]) begin
                pick_idx = IDX_W'(c);
                pick_hit = 1'b1;
            end
        end
        pick_thr = crosses[pick_idx];
    end

    // Result register: one cycle after the query.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_vld       <= 1'b0;
            sel_idx       <= '0;
            sel_hit       <= 1'b0;
            sel_throttled <= 1'b0;
        end else begin
            sel_vld       <= qry_vld;
            sel_idx       <= qry_vld ? pick_idx : '0;
            sel_hit       <= qry_vld & pick_hit;
            sel_throttled <= qry_vld & pick_thr;
        end
    end
endmodule

// File: rtl/hotspot_throttle.sv
// Top: per-switch windowed hotspot monitors, a shared window timer, a random
// source and the ranked path chooser.
// Assumes one flit pulse per switch per cycle at most.
module hotspot_throttle
    import hs_pkg::*;
#(
    parameter int NUM_SW       = 8,
    parameter int NCAND        = 4,
    parameter int WIN_CYCLES   = 100,
    parameter int THRESH_FLITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SW-1:0]       flit_evt,
    input  logic                    qry_vld,
    input  logic [NCAND*NUM_SW-1:0] qry_paths,
    output logic [NUM_SW-1:0]       avoid_list,
    output logic [3*NUM_SW-1:0]     hot_count,
    output logic                    sel_vld,
    output logic [((NCAND > 1) ? $clog2(NCAND) : 1)-1:0] sel_idx,
    output logic                    sel_hit,
    output logic                    sel_throttled
);
    logic        win_end;
    logic [15:0] rnd;

    hs_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .win_end(win_end)
    );

    for (genvar s = 0; s < NUM_SW; s++) begin : g_mon
        hs_switch_mon #(.WIN_CYCLES(WIN_CYCLES), .THRESH_FLITS(THRESH_FLITS)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .flit_evt (flit_evt[s]),
            .win_end  (win_end),
            .listed   (avoid_list[s]),
            .run_cnt  (hot_count[RUN_W*s +: RUN_W])
        );
    end

    hs_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    hs_path_pick #(.NUM_SW(NUM_SW), .NCAND(NCAND)) u_pick (
        .clk           (clk),
        .rst_n         (rst_n),
        .qry_vld       (qry_vld),
        .qry_paths     (qry_paths),
        .avoid_list    (avoid_list),
        .run_flat      (hot_count),
        .rnd_byte      (rnd[15:8]),
        .sel_vld       (sel_vld),
        .sel_idx       (sel_idx),
        .sel_hit       (sel_hit),
        .sel_throttled (sel_throttled)
    );
endmodule

// File: rtl/hotspot_throttle_chk.sv
// Checker for hotspot_throttle: timing of list updates, run-count stepping and
// the query-to-result relation. Attached by bind below.
module hotspot_throttle_chk #(
    parameter int NUM_SW = 8,
    parameter int NCAND  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    win_end,
    input logic                    qry_vld,
    input logic [NCAND*NUM_SW-1:0] qry_paths,
    input logic [NUM_SW-1:0]       avoid_list,
    input logic [3*NUM_SW-1:0]     hot_count,
    input logic                    sel_vld,
    input logic [((NCAND > 1) ? $clog2(NCAND) : 1)-1:0] sel_idx,
    input logic                    sel_hit,
    input logic                    sel_throttled
);
    // R5: list and run counts hold between window boundaries.
    assert_list_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_end) |-> ($stable(avoid_list) && $stable(hot_count)));

    for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
        // R4: listed exactly when the run count is non-zero.
        assert_list_matches_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
            avoid_list[s] == (hot_count[3*s +: 3] != 3'd0));
        // R4: a non-zero run count after a boundary is the previous one plus one, held at 7.
        assert_run_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(win_end) && hot_count[3*s +: 3] != 3'd0) |->
            (hot_count[3*s +: 3] == (($past(hot_count[3*s +: 3]) == 3'd7) ? 3'd7
                                     : $past(hot_count[3*s +: 3]) + 3'd1)));
    end

    // R10: every query is answered in the next cycle, and only then.
    assert_answer_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        qry_vld |=> sel_vld);
    assert_quiet_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_vld |=> !sel_vld);

    // R8: a preferred candidate clear of listed switches is chosen and accepted.
    assert_clear_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_vld && ((qry_paths[NUM_SW-1:0] & avoid_list) == '0)) |=>
        (sel_idx == '0 && sel_hit && !sel_throttled));

    // R7: a chosen path that crosses no listed switch is always an accepted one.
    assert_clear_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && !sel_throttled) |-> sel_hit);
endmodule

bind hotspot_throttle hotspot_throttle_chk #(.NUM_SW(NUM_SW), .NCAND(NCAND)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .win_end       (win_end),
    .qry_vld       (qry_vld),
    .qry_paths     (qry_paths),
    .avoid_list    (avoid_list),
    .hot_count     (hot_count),
    .sel_vld       (sel_vld),
    .sel_idx       (sel_idx),
    .sel_hit       (sel_hit),
    .sel_throttled (sel_throttled)
);

// File: tb/hotspot_throttle_bench.sv
// Bench: behavioural reference model advanced on each rising edge, compared with
// the design's outputs at every falling edge.
module hotspot_throttle_bench;
    localparam int NS  = 4;
    localparam int NC  = 3;
    localparam int WIN = 16;
    localparam int TH  = 3;
    localparam int IW  = 2;
    localparam int RUN_CYCLES = 14 * WIN;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NS-1:0]      flit_evt = '0;
    logic               qry_vld = 1'b0;
    logic [NC*NS-1:0]   qry_paths = '0;
    logic [NS-1:0]      avoid_list;
    logic [3*NS-1:0]    hot_count;
    logic               sel_vld;
    logic [IW-1:0]      sel_idx;
    logic               sel_hit;
    logic               sel_throttled;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int seen_default = 0;
    int seen_thr_hit = 0;

    // Reference model state.
    int m_flits[NS];
    int m_run[NS];
    int m_pos;
    int m_lfsr;
    int m_sel_vld, m_sel_idx, m_sel_hit, m_sel_thr;

    always #4 clk = ~clk;

    hotspot_throttle #(.NUM_SW(NS), .NCAND(NC), .WIN_CYCLES(WIN), .THRESH_FLITS(TH)) u_hotspot_throttle (
        .clk(clk), .rst_n(rst_n), .flit_evt(flit_evt), .qry_vld(qry_vld), .qry_paths(qry_paths),
        .avoid_list(avoid_list), .hot_count(hot_count), .sel_vld(sel_vld), .sel_idx(sel_idx),
        .sel_hit(sel_hit), .sel_throttled(sel_throttled)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model: advances on each edge from the bench-driven inputs only.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_flits[s]) begin m_flits[s] = 0; m_run[s] = 0; end
            m_pos = 0; m_lfsr = 16'hACE1;
            m_sel_vld = 0; m_sel_idx = 0; m_sel_hit = 0; m_sel_thr = 0;
        end else begin
            int r;
            r = (m_lfsr >> 8) & 255;
            m_sel_vld = qry_vld; m_sel_idx = 0; m_sel_hit = 0; m_sel_thr = 0;
            if (qry_vld) begin
                for (int c = NC - 1; c >= 0; c--) begin
                    int prod;
                    prod = 256;
                    for (int s = 0; s < NS; s++)
                        if (qry_paths[NS*c + s] && m_run[s] > 0) prod = prod >> m_run[s];
                    if (r < prod) begin m_sel_idx = c; m_sel_hit = 1; end
                end
                for (int s = 0; s < NS; s++)
                    if (qry_paths[NS*m_sel_idx + s] && m_run[s] > 0) m_sel_thr = 1;
            end
            for (int s = 0; s < NS; s++) m_flits[s] += flit_evt[s];
            if (m_pos == WIN - 1) begin
                for (int s = 0; s < NS; s++) begin
                    if (m_flits[s] > TH) m_run[s] = (m_run[s] < 7) ? m_run[s] + 1 : 7;
                    else                 m_run[s] = 0;
                    m_flits[s] = 0;
                end
                m_pos = 0;
            end else m_pos++;
            m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1)) & 16'hFFFF;
        end
    end

    task automatic compare_all();
        for (int s = 0; s < NS; s++) begin
            check("R2/R3 avoid_list bit", int'(avoid_list[s]), (m_run[s] > 0) ? 1 : 0);
            check("R4 run count", int'(hot_count[3*s +: 3]), m_run[s]);
        end
        check("R10 sel_vld", int'(sel_vld), m_sel_vld);
        if (m_sel_vld != 0) begin
            check("R8 sel_idx", int'(sel_idx), m_sel_idx);
            check("R6/R7/R9 sel_hit", int'(sel_hit), m_sel_hit);
            check("R10 sel_throttled", int'(sel_throttled), m_sel_thr);
            if (sel_hit == 1'b0) seen_default++;
            if (sel_hit && sel_throttled) seen_thr_hit++;
        end
    endtask

    int unsigned xs = 32'h1234_5678;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 avoid_list in reset", int'(avoid_list), 0);
        check("R1 hot_count in reset", int'(hot_count), 0);
        check("R1 sel_vld in reset", int'(sel_vld), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            int w, p;
            if (cyc > 0) @(negedge clk);
            compare_all();
            w = cyc / WIN; p = cyc % WIN;
            xs ^= xs << 13; xs ^= xs >> 17; xs ^= xs << 5;
            // sw0 always over; sw1 exactly at threshold (one extra in window 8, last cycle);
            // sw2 one over in odd windows; sw3 over in windows 1..4 only.
            flit_evt[0] = 1'b1;
            flit_evt[1] = (p < TH) || (w == 8 && p == WIN - 1);
            flit_evt[2] = (w % 2 == 1) && (p < TH + 1);
            flit_evt[3] = (w >= 1 && w <= 4) && (p % 2 == 0);
            if (w == 5) begin
                // R9: every candidate crosses sw0 (run 5) and sw3 (run 4): ratio 0.
                qry_vld   = 1'b1;
                qry_paths = {NC{4'b1001}};
            end else begin
                qry_vld   = xs[0] | xs[1];
                qry_paths = xs[NC*NS+3:4];
            end
        end
        @(negedge clk);
        compare_all();
        check("R9 fallback observed", (seen_default > 0) ? 1 : 0, 1);
        check("R7 throttled path accepted observed", (seen_thr_hit > 0) ? 1 : 0, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (RUN_CYCLES + 1000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule